// File: doc/BRIEF.md
# Store Buffer Drain Timing Model

This block estimates how long a processor waits on a bounded buffer of posted stores. It holds no data. Each buffer slot holds only the number of memory cycles that one posted store still needs before it reaches memory. The buffered stores drain one after another, oldest first, in the background. A free-running cycle counter timestamps every access.

When a store or load strobe arrives, the block first works out how much time has passed since the previous access. It retires every buffered store that has finished in that time, and it charges any leftover time against the oldest store that is still pending. A store that meets a full buffer must wait for the oldest entry to finish. A load must wait until every buffered store has finished. The wait is reported for each access one cycle after its strobe. A running total of wait cycles and a running total of store cost cycles are also kept.

The effective buffer length comes from a runtime input. That input is clamped to the range from one up to the built capacity.

Top module: `sbdt_store_drain`

## Requirements
- R1: After reset the occupancy, both totals, the done flag and the reported stall are all zero. The time of the previous access is also cleared.
- R2: At each access, the elapsed time is the cycle count minus the previous-access time. This value is signed. While entries remain and the elapsed time is at least the oldest entry's remaining cost, that entry is retired and its cost is subtracted from the elapsed time.
- R3: If entries remain after retirement, the leftover elapsed time is subtracted from the oldest entry's remaining cost. A negative leftover therefore raises that cost.
- R4: On a store, if the occupancy after retirement is at least the effective limit, exactly one oldest entry is removed. Its remaining cost is the stall. The new cost is then appended, so the occupancy never exceeds the capacity. If the occupancy is below the limit, the stall is 0.
- R5: On a load, the stall is the sum of the remaining costs of all entries after retirement, and the occupancy becomes 0.
- R6: `done` is high for exactly the one cycle after a cycle in which either strobe was high, and low otherwise. `stall_cyc` carries that access's stall while `done` is high.
- R7: The effective limit is `lim_cfg`, except that 0 is used as 1 and any value above the capacity (8 by default) is used as the capacity.
- R8: `wait_total` accumulates every reported stall. `store_total` accumulates the cost of every accepted store.
- R9: When both strobes are high in the same cycle, only the load is performed. The store is ignored: nothing is appended and `store_total` does not change.
- R10: After any access, the previous-access time becomes the access cycle plus that access's stall. Later elapsed times are measured from this shifted reference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| st_req | input | 1 | Store strobe |
| ld_req | input | 1 | Load strobe (wins over store) |
| st_cost | input | COST_W | Memory cycles the store needs |
| lim_cfg | input | CNT_W | Requested buffer length (clamped) |
| done | output | 1 | Result valid, one cycle after a strobe |
| stall_cyc | output | STALL_W | Stall cycles for the access |
| occ | output | CNT_W | Current number of buffered stores |
| wait_total | output | ACC_W | Accumulated stall cycles |
| store_total | output | ACC_W | Accumulated store cost cycles |

## Verification
Long idle gaps before a store separate correct retirement from a buffer that never drains. Short gaps followed by a load check the partial-credit arithmetic on the oldest entry. Back-to-back stores against a small limit check the full-buffer stall. A store followed at once by a load checks the shifted time reference, because that load can see a negative elapsed time. Limits of 0 and 15 probe the clamp. Both strobes high together must behave as a pure load. A long pseudo-random mix of costs, limits, gaps and access kinds is compared against a queue-based model on every access.

// File: rtl/sbdt_pkg.sv
// Package for the store buffer drain timing model.
// Holds the access kind encoding and a ring index helper.
// Assumes every ring offset passed in is below twice the capacity.
package sbdt_pkg;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_LOAD  = 2'd2
    } acc_kind_t;

    // Add an offset to a ring position and wrap at the capacity.
    function automatic int unsigned ring_add(input int unsigned base,
                                             input int unsigned off,
                                             input int unsigned cap);
        int unsigned s;
        s = base + off;
        if (s >= cap) s = s - cap;
        return s;
    endfunction

endpackage

// File: rtl/sbdt_tick.sv
// Free-running cycle counter used as the time base.
// Assumes wrap-around of TIME_W bits is acceptable, because only differences are used.
module sbdt_tick #(
    parameter int TIME_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [TIME_W-1:0] now
);

    // Count cycles since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) now <= '0;
        else        now <= now + 1'b1;
    end

endmodule

// File: rtl/sbdt_retire.sv
// Retires the buffered stores that finished during the elapsed time.
// Then charges the leftover time against the oldest remaining entry.
// Purely combinational. Assumes CAP >= 2 and TIME_W > ENT_W.
module sbdt_retire
    import sbdt_pkg::*;
#(
    parameter int CAP    = 8,
    parameter int ENT_W  = 12,
    parameter int TIME_W = 32,
    parameter int PTR_W  = 3,
    parameter int CNT_W  = 4
) (
    input  logic [CAP-1:0][ENT_W-1:0] ent_i,
    input  logic [PTR_W-1:0]          tail_i,
    input  logic [CNT_W-1:0]          cnt_i,
    input  logic signed [TIME_W-1:0]  elapsed_i,
    output logic [CAP-1:0][ENT_W-1:0] ent_o,
    output logic [PTR_W-1:0]          tail_o,
    output logic [CNT_W-1:0]          cnt_o
);

    localparam int PAD_W = TIME_W - ENT_W;

    logic signed [TIME_W-1:0] rem;
    logic                     stop;
    int unsigned              nret;
    logic [PTR_W-1:0]         idx;
    logic signed [TIME_W-1:0] cost_s;

    // Walk the entries oldest first and retire each one that fits in the remaining time.
    always_comb begin
        rem    = elapsed_i;
        stop   = 1'b0;
        nret   = 0;
        idx    = '0;
        cost_s = '0;
        for (int i = 0; i < CAP; i++) begin
            idx    = PTR_W'(ring_add(int'(tail_i), i, CAP));
            cost_s = $signed({{PAD_W{1'b0}}, ent_i[idx]});
            if (!stop && (i < int'(cnt_i)) && (rem >= cost_s)) begin
                rem  = rem - cost_s;
                nret = nret + 1;
            end else begin
                stop = 1'b1;
            end
        end
    end

    // Produce the new oldest position and count, and charge the leftover to the oldest entry.
    always_comb begin
        ent_o  = ent_i;
        tail_o = PTR_W'(ring_add(int'(tail_i), nret, CAP));
        cnt_o  = cnt_i - CNT_W'(nret);
        if (cnt_o != '0) ent_o[tail_o] = ent_i[tail_o] - rem[ENT_W-1:0];
    end

endmodule

// File: rtl/sbdt_drain.sv
// Computes the stall of one access from the entries left after retirement.
// A store removes at most the oldest entry when the buffer is at its limit.
// A load drains every entry. Purely combinational. Assumes CAP >= 2.
module sbdt_drain
    import sbdt_pkg::*;
#(
    parameter int CAP     = 8,
    parameter int ENT_W   = 12,
    parameter int PTR_W   = 3,
    parameter int CNT_W   = 4,
    parameter int STALL_W = 16
) (
    input  logic [CAP-1:0][ENT_W-1:0] ent_i,
    input  logic [PTR_W-1:0]          tail_i,
    input  logic [CNT_W-1:0]          cnt_i,
    input  logic [CNT_W-1:0]          lim_i,
    input  acc_kind_t                 kind_i,
    output logic [STALL_W-1:0]        stall_o,
    output logic [PTR_W-1:0]          tail_o,
    output logic [CNT_W-1:0]          cnt_o
);

    logic [CNT_W-1:0]   lim_eff;
    logic [STALL_W-1:0] sum;

    // Clamp the requested length to the range from one to the capacity.
    always_comb begin
        if (lim_i == '0)                    lim_eff = CNT_W'(1);
        else if (int'(lim_i) > CAP)         lim_eff = CNT_W'(CAP);
        else                                lim_eff = lim_i;
    end

    // Sum the remaining cost of every live entry, for a full drain.
    always_comb begin
        sum = '0;
        for (int i = 0; i < CAP; i++) begin
            if (i < int'(cnt_i))
                sum = sum + STALL_W'(ent_i[PTR_W'(ring_add(int'(tail_i), i, CAP))]);
        end
    end

    // Choose the stall and the removal depending on the access kind.
    always_comb begin
        stall_o = '0;
        tail_o  = tail_i;
        cnt_o   = cnt_i;
        unique case (kind_i)
            ACC_LOAD: begin
                stall_o = sum;
                tail_o  = PTR_W'(ring_add(int'(tail_i), int'(cnt_i), CAP));
                cnt_o   = '0;
            end
            ACC_STORE: begin
                if (cnt_i >= lim_eff) begin
                    stall_o = STALL_W'(ent_i[tail_i]);
                    tail_o  = PTR_W'(ring_add(int'(tail_i), 1, CAP));
                    cnt_o   = cnt_i - 1'b1;
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/sbdt_store_drain.sv
// Top of the store buffer drain timing model.
// Keeps a ring of remaining store costs, a previous-access time and two totals.
// Each strobe is resolved in its own cycle and reported one cycle later.
// Assumes at most one access per cycle, with load taking precedence over store.
module sbdt_store_drain
    import sbdt_pkg::*;
#(
    parameter int CAP    = 8,
    parameter int COST_W = 8,
    parameter int TIME_W = 32,
    parameter int ACC_W  = 32,
    localparam int PTR_W   = $clog2(CAP),
    localparam int CNT_W   = $clog2(CAP + 1),
    localparam int ENT_W   = COST_W + CNT_W,
    localparam int STALL_W = ENT_W + CNT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               st_req,
    input  logic               ld_req,
    input  logic [COST_W-1:0]  st_cost,
    input  logic [CNT_W-1:0]   lim_cfg,
    output logic               done,
    output logic [STALL_W-1:0] stall_cyc,
    output logic [CNT_W-1:0]   occ,
    output logic [ACC_W-1:0]   wait_total,
    output logic [ACC_W-1:0]   store_total
);

    acc_kind_t                 kind;
    logic                      acc;
    logic [TIME_W-1:0]         now;
    logic [TIME_W-1:0]         prev_q;
    logic [PTR_W-1:0]          head_q, tail_q, tail1, tail2;
    logic [CNT_W-1:0]          cnt_q, cnt1, cnt2;
    logic [CAP-1:0][ENT_W-1:0] ent_q, ent_adj;
    logic signed [TIME_W-1:0]  elapsed;
    logic [STALL_W-1:0]        stall;
    logic                      done_q;
    logic [STALL_W-1:0]        stall_q;
    logic [ACC_W-1:0]          wait_q, stot_q;

    // Decode the access kind; a load wins when both strobes are high.
    always_comb begin
        if (ld_req)      kind = ACC_LOAD;
        else if (st_req) kind = ACC_STORE;
        else             kind = ACC_IDLE;
    end
    assign acc     = st_req | ld_req;
    assign elapsed = $signed(now - prev_q);

    sbdt_tick #(.TIME_W(TIME_W)) tick_i (
        .clk (clk),
        .rst_n (rst_n),
        .now (now)
    );

    sbdt_retire #(
        .CAP(CAP), .ENT_W(ENT_W), .TIME_W(TIME_W), .PTR_W(PTR_W), .CNT_W(CNT_W)
    ) retire_i (
        .ent_i     (ent_q),
        .tail_i    (tail_q),
        .cnt_i     (cnt_q),
        .elapsed_i (elapsed),
        .ent_o     (ent_adj),
        .tail_o    (tail1),
        .cnt_o     (cnt1)
    );

    sbdt_drain #(
        .CAP(CAP), .ENT_W(ENT_W), .PTR_W(PTR_W), .CNT_W(CNT_W), .STALL_W(STALL_W)
    ) drain_i (
        .ent_i   (ent_adj),
        .tail_i  (tail1),
        .cnt_i   (cnt1),
        .lim_i   (lim_cfg),
        .kind_i  (kind),
        .stall_o (stall),
        .tail_o  (tail2),
        .cnt_o   (cnt2)
    );

    // One register per slot: a store writes its cost at the head, any other access keeps the adjusted value.
    for (genvar g = 0; g < CAP; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                ent_q[g] <= '0;
            else if (acc) begin
                if ((kind == ACC_STORE) && (int'(head_q) == g))
                    ent_q[g] <= ENT_W'(st_cost);
                else
                    ent_q[g] <= ent_adj[g];
            end
        end
    end

    // Ring pointers, occupancy and the time reference.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
            cnt_q  <= '0;
            prev_q <= '0;
        end else if (acc) begin
            tail_q <= tail2;
            prev_q <= now + TIME_W'(stall);
            if (kind == ACC_STORE) begin
                head_q <= PTR_W'(ring_add(int'(head_q), 1, CAP));
                cnt_q  <= cnt2 + 1'b1;
            end else begin
                cnt_q  <= cnt2;
            end
        end
    end

    // Result register and running totals.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q  <= 1'b0;
            stall_q <= '0;
            wait_q  <= '0;
            stot_q  <= '0;
        end else begin
            done_q <= acc;
            if (acc) begin
                stall_q <= stall;
                wait_q  <= wait_q + ACC_W'(stall);
            end
            if (kind == ACC_STORE) stot_q <= stot_q + ACC_W'(st_cost);
        end
    end

    assign done        = done_q;
    assign stall_cyc   = stall_q;
    assign occ         = cnt_q;
    assign wait_total  = wait_q;
    assign store_total = stot_q;

    // R6: a strobe is reported in the next cycle.
    a_r6_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> done_q);
    // R6: no strobe means no report in the next cycle.
    a_r6_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> !done_q);
    // R5: a load leaves the buffer empty.
    a_r5_load_empties: assert property (@(posedge clk) disable iff (!rst_n)
        ld_req |=> (cnt_q == '0));
    // R4: the occupancy never goes beyond the capacity.
    a_r4_occ_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt_q) <= CAP);
    // R4: an accepted store always leaves at least one entry.
    a_r4_store_present: assert property (@(posedge clk) disable iff (!rst_n)
        (st_req && !ld_req) |=> (cnt_q != '0));
    // R9: a store that comes with a load adds nothing to the store total.
    a_r9_store_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (st_req && ld_req) |=> $stable(stot_q));
    // R8: the wait total moves only after an access.
    a_r8_wait_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> $stable(wait_q));

endmodule

// File: tb/sbdt_store_drain_tb_top.sv
// Bench: a behavioural queue model is compared with the design at every access and on every idle cycle.
module sbdt_store_drain_tb_top;

    localparam int CAP = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        st_req = 1'b0;
    logic        ld_req = 1'b0;
    logic [7:0]  st_cost = '0;
    logic [3:0]  lim_cfg = '0;
    logic        done;
    logic [15:0] stall_cyc;
    logic [3:0]  occ;
    logic [31:0] wait_total;
    logic [31:0] store_total;

    int q[$];
    int m_prev = 0;
    int m_wait = 0;
    int m_stot = 0;
    int cyc = 0;
    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    // Count the cycles since reset release, which mirrors the design's time base.
    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    sbdt_store_drain dut_i (
        .clk (clk), .rst_n (rst_n), .st_req (st_req), .ld_req (ld_req),
        .st_cost (st_cost), .lim_cfg (lim_cfg), .done (done),
        .stall_cyc (stall_cyc), .occ (occ), .wait_total (wait_total),
        .store_total (store_total)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reference model of one access at time now; returns the expected stall.
    function automatic int model(input bit s, input bit l, input int cost, input int lim, input int now);
        int d, st, lm;
        d = now - m_prev;
        m_prev = now;
        while (q.size() > 0 && d >= q[0]) begin
            d -= q[0];
            void'(q.pop_front());
        end
        if (q.size() > 0) q[0] -= d;
        st = 0;
        if (l) begin
            foreach (q[k]) st += q[k];
            q.delete();
        end else if (s) begin
            lm = (lim == 0) ? 1 : ((lim > CAP) ? CAP : lim);
            if (q.size() >= lm) begin
                st = q[0];
                void'(q.pop_front());
            end
            q.push_back(cost);
            m_stot += cost;
        end
        m_prev += st;
        m_wait += st;
        return st;
    endfunction

    task automatic access(input bit s, input bit l, input int cost, input int lim, input string tag);
        int exp;
        @(negedge clk);
        st_req = s; ld_req = l; st_cost = 8'(cost); lim_cfg = 4'(lim);
        exp = model(s, l, cost, lim, cyc);
        @(negedge clk);
        st_req = 0; ld_req = 0;
        chk(done == 1'b1, {tag, " R6 done"}, done, 1);
        chk(int'(stall_cyc) == exp, {tag, " stall"}, stall_cyc, exp);
        chk(int'(occ) == q.size(), {tag, " occupancy"}, occ, q.size());
        chk(int'(wait_total) == m_wait, {tag, " R8 wait total"}, wait_total, m_wait);
        chk(int'(store_total) == m_stot, {tag, " R8 store total"}, store_total, m_stot);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(done == 1'b0, "R6 idle done low", done, 0);
            chk(int'(occ) == q.size(), "R6 idle occupancy", occ, q.size());
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk(occ == 0, "R1 occ", occ, 0);
        chk(done == 0, "R1 done", done, 0);
        chk(stall_cyc == 0, "R1 stall", stall_cyc, 0);
        chk(wait_total == 0, "R1 wait", wait_total, 0);
        chk(store_total == 0, "R1 store total", store_total, 0);
        // R4: stores against a limit of 3
        for (int i = 0; i < 5; i++) access(1, 0, 20, 3, "R4 full stall");
        // R2: long idle retires everything, then a new store
        idle(120);
        access(1, 0, 5, 3, "R2 retire");
        // R3: partial credit, then R5 full drain
        access(1, 0, 30, 8, "R3 partial");
        idle(10);
        access(0, 1, 0, 8, "R5 load drain");
        access(0, 1, 0, 8, "R5 load empty");
        // R7: limit 0 acts as 1
        access(1, 0, 40, 0, "R7 lim zero a");
        access(1, 0, 40, 0, "R7 lim zero b");
        // R7: limit 15 acts as the capacity
        for (int i = 0; i < 10; i++) access(1, 0, 50, 15, "R7 lim above cap");
        // R10: load right after a stalled store sees the shifted reference
        access(1, 0, 9, 15, "R10 stalled store");
        access(0, 1, 0, 15, "R10 load after stall");
        // R9: both strobes act as a load
        access(1, 0, 25, 4, "R9 setup");
        access(1, 1, 99, 4, "R9 both strobes");
        access(1, 0, 0, 4, "R4 zero cost store");
        // R8: long mixed sequence
        for (int i = 0; i < 400; i++) begin
            int k;
            k = $urandom_range(0, 9);
            access(k < 8, k >= 7, $urandom_range(0, 40), $urandom_range(0, 15), "R8 mixed");
            idle($urandom_range(0, 15));
        end
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule